// File: doc/BRIEF.md
# Filtered System Reset Generator

This block drives an active-low system reset for a chip or board domain from two causes. The first is an active-high undervoltage flag from an external supply comparator. The second is an active-low manual reset input, which may come from a push-button, from other logic, or from a watchdog fault pulse fed back into it. Each input passes through a two-flop synchronizer. It then goes through a qualifier that accepts a cause only after the cause has stayed active for a set number of consecutive clock ticks, so short glitches and dips never reach the reset.

While either qualified cause is active, the reset is held low. Once every cause has cleared, a stretch counter keeps the reset low for a fixed number of ticks before it lets go. A cause that comes back during the stretch restarts the full period. The same stretch applies after power-on. While the manual cause is qualified, the block also raises a watchdog-clear output, so that a companion watchdog holds its timer at zero and its fault output inactive. All time constants are parameters in clock ticks. With a 250 MHz clock, the defaults match a 1 µs minimum manual-reset low time, a 20 µs undervoltage dip filter and a 180 ms stretch.

Top module: `sys_reset_gen`

## Requirements
- R1: While `por_n` is low at a clock edge, the next cycle shows `sys_rst_n` low and `wdog_clr` low.
- R2: With no cause active, `sys_rst_n` rises at exactly the `STRETCH_TICKS`-th rising clock edge after `por_n` is first sampled high, and stays low before it.
- R3: The manual input is active when `man_rst_n` is 0. If it is held low for `MR_MIN_TICKS` consecutive rising edges or more, `sys_rst_n` falls at the (`MR_MIN_TICKS`+3)-th edge counted from the first edge that samples it low. A low pulse of fewer edges never moves `sys_rst_n`.
- R4: The undervoltage input is active when `uv_flag` is 1. A pulse held for `UV_MIN_TICKS` edges or more asserts the reset with the same latency rule as R3. A shorter pulse never moves `sys_rst_n`.
- R5: While either qualified cause is active, `sys_rst_n` stays low.
- R6: After the last cause input returns inactive at the port, `sys_rst_n` rises at exactly the (`STRETCH_TICKS`+3)-th edge that samples it inactive. This holds for a long manual pulse such as a looped-back watchdog fault pulse.
- R7: A cause that qualifies again during the stretch restarts it, so the release follows R6 counted from the second cause's release.
- R8: `wdog_clr` is 1 exactly while the manual cause is qualified, with the same latency as the reset assertion in R3. It drops one edge after the manual cause is released. It stays 0 for any undervoltage cause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Synchronous active-low power-on reset of the block |
| uv_flag | input | 1 | Asynchronous undervoltage flag, 1 = supply low |
| man_rst_n | input | 1 | Asynchronous manual reset, 0 = request reset |
| sys_rst_n | output | 1 | Active-low system reset output |
| wdog_clr | output | 1 | 1 while the qualified manual reset holds the watchdog cleared |

## Verification
A cause is seen by the synchronizer on its first sampling edge and is visible to the qualifier two edges later. The qualifier flags it after its hold count, and the output register changes one edge after that. So assertion is due at hold+3 edges, `wdog_clr` drops 4 edges after release, and the reset lets go at stretch+3 edges after release. The bench drives inputs on the falling edge, counts rising edges from the first sampling edge, and reads outputs 1 ns after the exact edge due and after the edge just before it. The table-driven part accumulates whether the reset or the clear went active anywhere in a window, which covers the pulses that must be rejected.

// File: rtl/rg_pkg.sv
// Shared helpers for the reset generator.
// Assumes: tick counts are positive integers.
package rg_pkg;

    // Width of a counter that must hold values 0..max_val.
    function automatic int cnt_width(input int max_val);
        return (max_val > 1) ? $clog2(max_val + 1) : 1;
    endfunction

    // Default constants in ticks of a 250 MHz clock.
    localparam int DEF_MR_MIN_TICKS  = 250;
    localparam int DEF_UV_MIN_TICKS  = 5000;
    localparam int DEF_STRETCH_TICKS = 45_000_000;

endpackage

// File: rtl/rg_sync.sv
// Two-flop synchronizer, one lane per bit.
// Assumes: inputs are asynchronous levels; RST_VAL sets each lane's reset value.
module rg_sync #(
    parameter int              WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_lane
        logic meta_q;
        logic stab_q;

        // Two-stage capture of one asynchronous lane.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[g];
                stab_q <= RST_VAL[g];
            end else begin
                meta_q <= d_async[g];
                stab_q <= meta_q;
            end
        end

        assign q_sync[g] = stab_q;
    end

endmodule

// File: rtl/rg_qualify.sv
// Level qualifier: the output goes high once the input has been high for
// HOLD_TICKS consecutive edges, and drops on the first edge it sees low.
// Assumes: input is already synchronous; HOLD_TICKS >= 1.
module rg_qualify #(
    parameter int HOLD_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    output logic qual
);
    import rg_pkg::*;

    localparam int            CW   = cnt_width(HOLD_TICKS - 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

    logic [CW-1:0] run_q;
    logic          qual_q;

    // Count consecutive active samples and flag the level once it has held long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            qual_q <= 1'b0;
        end else if (!act) begin
            run_q  <= '0;
            qual_q <= 1'b0;
        end else if (run_q == LAST) begin
            qual_q <= 1'b1;
        end else begin
            run_q  <= run_q + 1'b1;
        end
    end

    assign qual = qual_q;

endmodule

// File: rtl/rg_stretch.sv
// Reset stretcher: holds the reset low while a cause is present and for
// STRETCH_TICKS edges after the last cause clears; a new cause restarts it.
// Assumes: cause is synchronous; the block reset starts a full period.
module rg_stretch #(
    parameter int STRETCH_TICKS = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cause,
    output logic rst_out_n
);
    import rg_pkg::*;

    localparam int            CW   = cnt_width(STRETCH_TICKS - 1);
    localparam logic [CW-1:0] LAST = CW'(STRETCH_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          out_q;

    // Restart on any cause, count quiet cycles, and release at the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n || cause) begin
            cnt_q <= '0;
            out_q <= 1'b0;
        end else if (!out_q) begin
            if (cnt_q == LAST) begin
                out_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign rst_out_n = out_q;

endmodule

// File: rtl/sys_reset_gen.sv
// Top of the reset generator: synchronizes both causes, qualifies each against
// its own minimum active time, merges them and stretches the system reset.
// Also drives the watchdog-clear level from the qualified manual cause.
// Assumes: STRETCH_TICKS exceeds the qualifier latencies, so a cause present at
// power-on is qualified before the first release.
module sys_reset_gen #(
    parameter int MR_MIN_TICKS  = rg_pkg::DEF_MR_MIN_TICKS,
    parameter int UV_MIN_TICKS  = rg_pkg::DEF_UV_MIN_TICKS,
    parameter int STRETCH_TICKS = rg_pkg::DEF_STRETCH_TICKS
) (
    input  logic clk,
    input  logic por_n,
    input  logic uv_flag,
    input  logic man_rst_n,
    output logic sys_rst_n,
    output logic wdog_clr
);

    localparam int NCAUSE = 2;
    localparam int IDX_MR = 0;
    localparam int IDX_UV = 1;

    logic [NCAUSE-1:0] raw_act;
    logic [NCAUSE-1:0] sync_act;
    logic              mr_qual;
    logic              uv_qual;
    logic              cause_any;
    logic              wdog_clr_q;

    // Both causes are carried as active-high levels from here on.
    assign raw_act[IDX_MR] = ~man_rst_n;
    assign raw_act[IDX_UV] = uv_flag;

    rg_sync #(
        .WIDTH   (NCAUSE),
        .RST_VAL ('0)
    ) u_sync (
        .clk     (clk),
        .rst_n   (por_n),
        .d_async (raw_act),
        .q_sync  (sync_act)
    );

    rg_qualify #(
        .HOLD_TICKS (MR_MIN_TICKS)
    ) u_mr_qual (
        .clk   (clk),
        .rst_n (por_n),
        .act   (sync_act[IDX_MR]),
        .qual  (mr_qual)
    );

    rg_qualify #(
        .HOLD_TICKS (UV_MIN_TICKS)
    ) u_uv_qual (
        .clk   (clk),
        .rst_n (por_n),
        .act   (sync_act[IDX_UV]),
        .qual  (uv_qual)
    );

    assign cause_any = mr_qual | uv_qual;

    rg_stretch #(
        .STRETCH_TICKS (STRETCH_TICKS)
    ) u_stretch (
        .clk       (clk),
        .rst_n     (por_n),
        .cause     (cause_any),
        .rst_out_n (sys_rst_n)
    );

    // Register the watchdog clear so that it changes on the same edge as the reset.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            wdog_clr_q <= 1'b0;
        end else begin
            wdog_clr_q <= mr_qual;
        end
    end

    assign wdog_clr = wdog_clr_q;

endmodule

// File: rtl/rg_checker.sv
// Property checker for sys_reset_gen, attached with bind.
// Assumes: por_n is the only reset; quiet_q counts cause-free cycles.
module rg_checker #(
    parameter int STRETCH_TICKS = 40
) (
    input logic clk,
    input logic por_n,
    input logic cause,
    input logic mr_q,
    input logic sys_rst_n,
    input logic wdog_clr
);
    import rg_pkg::*;

    localparam int            QW   = cnt_width(STRETCH_TICKS);
    localparam logic [QW-1:0] QMAX = QW'(STRETCH_TICKS);

    logic [QW-1:0] quiet_q;

    // Saturating count of consecutive cycles without a qualified cause.
    always_ff @(posedge clk) begin
        if (!por_n || cause) begin
            quiet_q <= '0;
        end else if (quiet_q != QMAX) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    AST_POR_HOLDS: assert property (@(posedge clk) !por_n |=> (!sys_rst_n && !wdog_clr)); // R1

    AST_CAUSE_HOLDS: assert property (@(posedge clk) disable iff (!por_n) cause |=> !sys_rst_n); // R5

    AST_FULL_STRETCH: assert property (@(posedge clk) disable iff (!por_n) $rose(sys_rst_n) |-> (quiet_q == QMAX)); // R6

    AST_WDCLR_WITH_MR: assert property (@(posedge clk) disable iff (!por_n) mr_q |=> (wdog_clr && !sys_rst_n)); // R8

    AST_WDCLR_DROPS: assert property (@(posedge clk) disable iff (!por_n) !mr_q |=> !wdog_clr); // R8

endmodule

bind sys_reset_gen rg_checker #(
    .STRETCH_TICKS (STRETCH_TICKS)
) u_rg_checker (
    .clk       (clk),
    .por_n     (por_n),
    .cause     (cause_any),
    .mr_q      (mr_qual),
    .sys_rst_n (sys_rst_n),
    .wdog_clr  (wdog_clr)
);

// File: tb/sys_reset_gen_tb.sv
module sys_reset_gen_tb;

    localparam int MRT = 8;
    localparam int UVT = 12;
    localparam int STR = 40;
    localparam int NV  = 11;

    // Vector fields: [17:10] manual low length, [9:2] undervoltage length,
    // [1] reset expected in window, [0] watchdog clear expected in window.
    localparam logic [17:0] TBL [NV] = '{
        {8'd0,  8'd0,  1'b0, 1'b0},
        {8'd3,  8'd0,  1'b0, 1'b0},
        {8'd7,  8'd0,  1'b0, 1'b0},
        {8'd8,  8'd0,  1'b1, 1'b1},
        {8'd25, 8'd0,  1'b1, 1'b1},
        {8'd0,  8'd4,  1'b0, 1'b0},
        {8'd0,  8'd11, 1'b0, 1'b0},
        {8'd0,  8'd12, 1'b1, 1'b0},
        {8'd0,  8'd40, 1'b1, 1'b0},
        {8'd7,  8'd11, 1'b0, 1'b0},
        {8'd8,  8'd11, 1'b1, 1'b1}
    };

    logic clk       = 1'b0;
    logic por_n     = 1'b0;
    logic uv_flag   = 1'b0;
    logic man_rst_n = 1'b1;
    logic sys_rst_n;
    logic wdog_clr;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;
    bit seen_low = 1'b0;
    bit seen_clr = 1'b0;

    always #2 clk = ~clk;

    sys_reset_gen #(
        .MR_MIN_TICKS  (MRT),
        .UV_MIN_TICKS  (UVT),
        .STRETCH_TICKS (STR)
    ) u_dut (
        .clk       (clk),
        .por_n     (por_n),
        .uv_flag   (uv_flag),
        .man_rst_n (man_rst_n),
        .sys_rst_n (sys_rst_n),
        .wdog_clr  (wdog_clr)
    );

    // Window monitor, sampled 1 ns after each rising edge.
    always @(posedge clk) begin
        #1;
        if (sys_rst_n === 1'b0) seen_low = 1'b1;
        if (wdog_clr === 1'b1) seen_clr = 1'b1;
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        // R1: reset state
        repeat (5) @(negedge clk);
        chk("R1 sys_rst_n in por", sys_rst_n, 1'b0);
        chk("R1 wdog_clr in por", wdog_clr, 1'b0);

        // R2: power-on release timing
        @(negedge clk) por_n = 1'b1;
        edges(STR - 1);
        chk("R2 low before release", sys_rst_n, 1'b0);
        edges(1);
        chk("R2 release edge", sys_rst_n, 1'b1);
        chk("R1 wdog_clr idle", wdog_clr, 1'b0);

        // R3/R8: manual assertion latency, long loopback-style pulse
        @(negedge clk) man_rst_n = 1'b0;
        edges(MRT + 2);
        chk("R3 not yet asserted", sys_rst_n, 1'b1);
        chk("R8 clr not yet", wdog_clr, 1'b0);
        edges(1);
        chk("R3 asserted", sys_rst_n, 1'b0);
        chk("R8 clr asserted", wdog_clr, 1'b1);
        repeat (100) @(negedge clk);
        chk("R5 held during cause", sys_rst_n, 1'b0);
        man_rst_n = 1'b1;
        edges(3);
        chk("R8 clr still high", wdog_clr, 1'b1);
        edges(1);
        chk("R8 clr dropped", wdog_clr, 1'b0);
        edges(STR - 2);
        chk("R6 low before release", sys_rst_n, 1'b0);
        edges(1);
        chk("R6 release edge", sys_rst_n, 1'b1);

        // R7: second cause during stretch restarts it
        @(negedge clk) man_rst_n = 1'b0;
        repeat (30) @(negedge clk);
        man_rst_n = 1'b1;
        edges(20);
        chk("R7 low within stretch", sys_rst_n, 1'b0);
        @(negedge clk) uv_flag = 1'b1;
        repeat (30) @(negedge clk);
        chk("R8 no clr for undervoltage", wdog_clr, 1'b0);
        uv_flag = 1'b0;
        edges(STR + 2);
        chk("R7 low before restarted release", sys_rst_n, 1'b0);
        edges(1);
        chk("R7 restarted release edge", sys_rst_n, 1'b1);

        // Vector table: filter boundaries for R3, R4, R8
        for (int v = 0; v < NV; v++) begin
            int mr_len;
            int uv_len;
            int span;
            mr_len = int'(TBL[v][17:10]);
            uv_len = int'(TBL[v][9:2]);
            span   = (mr_len > uv_len) ? mr_len : uv_len;
            @(negedge clk);
            seen_low = 1'b0;
            seen_clr = 1'b0;
            for (int i = 0; i < span; i++) begin
                man_rst_n = !(i < mr_len);
                uv_flag   = (i < uv_len);
                @(negedge clk);
            end
            man_rst_n = 1'b1;
            uv_flag   = 1'b0;
            edges(20);
            chk($sformatf("R3/R4 vector %0d reset seen", v), seen_low, TBL[v][1]);
            chk($sformatf("R8 vector %0d clear seen", v), seen_clr, TBL[v][0]);
            edges(STR + 10);
            chk($sformatf("R6 vector %0d released", v), sys_rst_n, 1'b1);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule